// File: doc/BRIEF.md
# Acquisition Frame Packetizer

This block turns buffered sample streams from four digitizer channels into framed 32-bit records. Each of the four channels (in-phase, delayed in-phase, quadrature, delayed quadrature) writes 16-bit samples into its own buffer. Once every buffer holds enough samples for a whole payload, the block emits one frame on a valid/ready stream. The frame has a six-word header, a payload drawn from each channel in turn, and a four-word trailer.

The header records a spare constant, the acquisition configuration, a 32-bit timestamp and a 32-bit frame tag. The timestamp and the tag each travel as an upper-half word and a lower-half word. The trailer repeats the tag, so a receiver can pair a header with its trailer. The trailer also carries a status word that flags any buffer that dropped samples since the previous frame. Start and end markers mark the first and last word of each frame.

Top module: `acq_frame_packer`

## Requirements
- R1: The first two header words are the header spare constant (parameter), then the configuration input value captured in the cycle the frame is launched.
- R2: The payload is 4×PAYLOAD_WORDS words. It takes PAYLOAD_WORDS words from channel 0, then from channels 1, 2 and 3 in that order, with samples in write order. Each word packs the older sample in bits [15:0] and the newer one in bits [31:16].
- R3: The trailer has four words in this order: the trailer spare constant (parameter), the status word, the tag upper half, the tag lower half.
- R4: Header words 3 and 4 carry, in bits [15:0] with zeros above, the upper and then the lower half of the timer. The timer counts clock cycles since reset was released, and the value sent is the one in the cycle the first header word first becomes valid.
- R5: Header words 5 and 6 and the last two trailer words carry the tag, upper half then lower half, each in bits [15:0]. The tag is 0 for the first frame after reset and rises by one per completed frame.
- R6: A frame is launched only when every channel buffer holds at least 2×PAYLOAD_WORDS samples. Otherwise the output valid stays low.
- R7: Each channel buffer holds FIFO_DEPTH samples. A write to a full buffer is dropped and sets that channel's bit (bit c for channel c) in status bits [3:0]. All other status bits are 0. Accepting the status word clears the bits it reported.
- R8: The start marker is high only on the first header word and the end marker only on the last trailer word.
- R9: While valid is high and ready is low, valid, data and both markers hold their values into the next cycle.
- R10: During and right after reset, valid is low and the tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_we | input | 4 | Per-channel sample write strobe |
| smp_din | input | 64 | Per-channel 16-bit samples, channel c at [16c+15:16c] |
| acq_cfg | input | 32 | Acquisition configuration word |
| fr_valid | output | 1 | Output word valid |
| fr_ready | input | 1 | Downstream ready |
| fr_data | output | 32 | Output word |
| fr_sof | output | 1 | First word of frame |
| fr_eof | output | 1 | Last word of frame |

## Verification
The assertions check on every cycle that the output holds under backpressure and that the start and end markers never coincide. They also check that a frame begins with its start marker, that the tag moves only at frame ends and by exactly one, that a dropped write sets its overflow flag, and that a frame never starts without enough buffered samples in every channel. Only the bench scenarios can show that the word order, the timestamp value, the sample packing, the channel rotation and the clear-on-report of the status flags are right. Those scenarios use random backpressure, a deliberately starved channel and a buffer driven past full.

// File: rtl/acq_frame_packer.sv
module acq_frame_packer #(
  parameter int                   SAMPLE_W      = 16,
  parameter int                   CH_SEL_W      = 2,
  parameter int                   FIFO_DEPTH    = 2048,
  parameter int                   PAYLOAD_WORDS = 8,
  parameter logic [2*SAMPLE_W-1:0] HDR_SPARE    = 32'h4844_0000,
  parameter logic [2*SAMPLE_W-1:0] TRL_SPARE    = 32'h5452_0000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [(1<<CH_SEL_W)-1:0]       smp_we,
  input  logic [(1<<CH_SEL_W)*SAMPLE_W-1:0] smp_din,
  input  logic [2*SAMPLE_W-1:0]          acq_cfg,
  output logic                           fr_valid,
  input  logic                           fr_ready,
  output logic [2*SAMPLE_W-1:0]          fr_data,
  output logic                           fr_sof,
  output logic                           fr_eof
);
  localparam int NCH    = 1 << CH_SEL_W;
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int HALF   = WORD_W / 2;
  localparam int AW     = $clog2(FIFO_DEPTH);
  localparam int CW     = AW + 1;
  localparam int NEED   = 2 * PAYLOAD_WORDS;
  localparam int PCW    = $clog2(PAYLOAD_WORDS + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_TRL} phase_t;

  phase_t              phase;
  logic [2:0]          hsel;
  logic [CH_SEL_W-1:0] csel;
  logic [PCW-1:0]      pcnt;
  logic [WORD_W-1:0]   tmr, ts_q, cfg_q, tag_q;
  logic [NCH-1:0]      ovf_q, snap_q, ovf_hit, enough, pop;
  logic [NCH*CW-1:0]   fill_bus;
  logic [WORD_W-1:0]   pay_w [NCH];
  logic                fire;

  assign fire = fr_valid && fr_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] mem [FIFO_DEPTH];
    logic [CW-1:0]       wp, rp, fill;
    logic [AW-1:0]       ra0, ra1;
    logic                full;

    assign fill = wp - rp;
    assign full = fill == CW'(FIFO_DEPTH);
    assign ovf_hit[c] = smp_we[c] && full;
    assign enough[c] = fill >= CW'(NEED);
    assign fill_bus[c*CW +: CW] = fill;
    assign ra0 = rp[AW-1:0];
    assign ra1 = rp[AW-1:0] + 1'b1;
    assign pay_w[c] = {mem[ra1], mem[ra0]};
    assign pop[c] = fire && phase == S_PAY && csel == CH_SEL_W'(c);

    always_ff @(posedge clk) begin
      if (smp_we[c] && !full) mem[wp[AW-1:0]] <= smp_din[c*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (smp_we[c] && !full) wp <= wp + 1'b1;
        if (pop[c]) rp <= rp + CW'(2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tmr <= '0;
    else     tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= S_IDLE;
      hsel   <= 3'd1;
      csel   <= '0;
      pcnt   <= '0;
      ts_q   <= '0;
      cfg_q  <= '0;
      tag_q  <= '0;
      snap_q <= '0;
    end else begin
      case (phase)
        S_IDLE: if (&enough) begin
          phase <= S_HDR;
          hsel  <= 3'd1;
          ts_q  <= tmr + 1'b1;
          cfg_q <= acq_cfg;
        end
        S_HDR: if (fire) begin
          if (hsel == 3'd6) begin
            phase <= S_PAY;
            csel  <= '0;
            pcnt  <= '0;
          end else hsel <= hsel + 1'b1;
        end
        S_PAY: if (fire) begin
          if (pcnt == PCW'(PAYLOAD_WORDS - 1)) begin
            pcnt <= '0;
            if (csel == CH_SEL_W'(NCH - 1)) begin
              phase <= S_TRL;
              hsel  <= 3'd1;
            end else csel <= csel + 1'b1;
          end else pcnt <= pcnt + 1'b1;
        end
        S_TRL: if (fire) begin
          if (hsel == 3'd1) snap_q <= ovf_q;
          if (hsel == 3'd4) begin
            phase <= S_IDLE;
            tag_q <= tag_q + 1'b1;
          end else hsel <= hsel + 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= '0;
    else if (fire && phase == S_TRL && hsel == 3'd2) ovf_q <= (ovf_q & ~snap_q) | ovf_hit;
    else ovf_q <= ovf_q | ovf_hit;
  end

  always_comb begin
    fr_data = '0;
    case (phase)
      S_HDR: case (hsel)
        3'd1: fr_data = HDR_SPARE;
        3'd2: fr_data = cfg_q;
        3'd3: fr_data = {{HALF{1'b0}}, ts_q[WORD_W-1:HALF]};
        3'd4: fr_data = {{HALF{1'b0}}, ts_q[HALF-1:0]};
        3'd5: fr_data = {{HALF{1'b0}}, tag_q[WORD_W-1:HALF]};
        3'd6: fr_data = {{HALF{1'b0}}, tag_q[HALF-1:0]};
        default: fr_data = '0;
      endcase
      S_PAY: fr_data = pay_w[csel];
      S_TRL: case (hsel)
        3'd1: fr_data = TRL_SPARE;
        3'd2: fr_data = {{(WORD_W-NCH){1'b0}}, snap_q};
        3'd3: fr_data = {{HALF{1'b0}}, tag_q[WORD_W-1:HALF]};
        3'd4: fr_data = {{HALF{1'b0}}, tag_q[HALF-1:0]};
        default: fr_data = '0;
      endcase
      default: fr_data = '0;
    endcase
  end

  assign fr_valid = phase != S_IDLE;
  assign fr_sof   = phase == S_HDR && hsel == 3'd1;
  assign fr_eof   = phase == S_TRL && hsel == 3'd4;

endmodule

// File: rtl/acq_frame_packer_chk.sv
module acq_frame_packer_chk #(
  parameter int NCH    = 4,
  parameter int CW     = 12,
  parameter int NEED   = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fr_valid,
  input logic              fr_ready,
  input logic [WORD_W-1:0] fr_data,
  input logic              fr_sof,
  input logic              fr_eof,
  input logic [WORD_W-1:0] tag_q,
  input logic [NCH-1:0]    ovf_q,
  input logic [NCH-1:0]    ovf_hit,
  input logic [NCH*CW-1:0] fill_bus
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    fr_valid && !fr_ready |=> fr_valid && $stable(fr_data) && $stable(fr_sof) && $stable(fr_eof));

  assert_markers_apart_R8: assert property (@(posedge clk) disable iff (rst)
    fr_valid |-> !(fr_sof && fr_eof));

  assert_frame_opens_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fr_valid) |-> fr_sof);

  assert_tag_step_R5: assert property (@(posedge clk) disable iff (rst)
    fr_valid && fr_ready && fr_eof |=> tag_q == $past(tag_q) + 1'b1);

  assert_tag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(fr_valid && fr_ready && fr_eof) |=> $stable(tag_q));

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> !fr_valid && tag_q == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ck
    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
      ovf_hit[c] |=> ovf_q[c]);
    assert_start_level_R6: assert property (@(posedge clk) disable iff (rst)
      fr_valid && fr_sof |-> fill_bus[c*CW +: CW] >= CW'(NEED));
  end
endmodule

bind acq_frame_packer acq_frame_packer_chk #(
  .NCH(NCH), .CW(CW), .NEED(NEED), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .fr_valid(fr_valid), .fr_ready(fr_ready),
  .fr_data(fr_data), .fr_sof(fr_sof), .fr_eof(fr_eof),
  .tag_q(tag_q), .ovf_q(ovf_q), .ovf_hit(ovf_hit), .fill_bus(fill_bus)
);

// File: tb/acq_frame_packer_tb_top.sv
`timescale 1ns/1ps
module acq_frame_packer_tb_top;
  localparam int P     = 4;
  localparam int DEPTH = 2048;
  localparam int FW    = 6 + 4*P + 4;
  localparam logic [31:0] H_SP = 32'h4844_5253;
  localparam logic [31:0] T_SP = 32'h5452_4C52;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  smp_we = '0;
  logic [63:0] smp_din = '0;
  logic [31:0] acq_cfg = 32'h1357_9BDF;
  logic        fr_valid, fr_ready, fr_sof, fr_eof;
  logic [31:0] fr_data;

  always #10 clk = ~clk;

  acq_frame_packer #(.FIFO_DEPTH(DEPTH), .PAYLOAD_WORDS(P),
                     .HDR_SPARE(H_SP), .TRL_SPARE(T_SP)) dut_i (
    .clk(clk), .rst(rst), .smp_we(smp_we), .smp_din(smp_din), .acq_cfg(acq_cfg),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data),
    .fr_sof(fr_sof), .fr_eof(fr_eof));

  int errs = 0, checks = 0;
  logic [31:0] exp_q[$];
  int          kind_q[$];
  logic [15:0] mdl [4][$];
  logic [13:0] seq [4];
  logic [3:0]  ovf_m = '0;
  logic [31:0] tag_m = '0;
  logic [31:0] cyc;
  logic        bp_on = 1'b0;
  logic        done = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic [31:0] v, input int k);
    exp_q.push_back(v);
    kind_q.push_back(k);
  endtask

  // scoreboard driver: turn model buffers into expected frames
  task automatic predict();
    while (mdl[0].size() >= 2*P && mdl[1].size() >= 2*P &&
           mdl[2].size() >= 2*P && mdl[3].size() >= 2*P) begin
      push_exp(H_SP, 0);
      push_exp(acq_cfg, 0);
      push_exp('0, 1);
      push_exp('0, 2);
      push_exp({16'h0, tag_m[31:16]}, 0);
      push_exp({16'h0, tag_m[15:0]}, 0);
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < P; w++) begin
          logic [15:0] lo, hi;
          lo = mdl[c].pop_front();
          hi = mdl[c].pop_front();
          push_exp({hi, lo}, 0);
        end
      push_exp(T_SP, 0);
      push_exp({28'h0, ovf_m}, 0);
      push_exp({16'h0, tag_m[31:16]}, 0);
      push_exp({16'h0, tag_m[15:0]}, 0);
      ovf_m = '0;
      tag_m = tag_m + 1;
    end
  endtask

  task automatic write_burst(input logic [3:0] mask, input int n);
    logic [15:0] vals [4][$];
    for (int i = 0; i < n; i++)
      for (int c = 0; c < 4; c++)
        if (mask[c]) begin
          logic [15:0] v;
          v = {c[1:0], seq[c]};
          seq[c] = seq[c] + 1'b1;
          vals[c].push_back(v);
          if (mdl[c].size() < DEPTH) mdl[c].push_back(v);
          else ovf_m[c] = 1'b1;
        end
    predict();
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      smp_we = mask;
      for (int c = 0; c < 4; c++)
        if (mask[c]) smp_din[c*16 +: 16] = vals[c][i];
    end
    @(posedge clk); #1;
    smp_we = '0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || fr_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0 && !fr_valid, "R6 drained", {31'h0, fr_valid}, 32'h0);
  endtask

  function automatic string req_of(input int i);
    if (i < 2) return "R1";
    if (i < 4) return "R4";
    if (i < 6) return "R5";
    if (i < FW - 4) return "R2";
    if (i == FW - 4) return "R3";
    if (i == FW - 3) return "R7";
    return "R5";
  endfunction

  // ready pattern
  initial begin
    logic [7:0] lf = 8'hA7;
    fr_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      fr_ready = bp_on ? (lf[0] | lf[3]) : 1'b1;
    end
  end

  // monitor
  int          widx = 0;
  logic        ts_seen_ok = 1'b0;
  logic [31:0] ts_seen;
  logic        p_stall = 1'b0, p_sof, p_eof;
  logic [31:0] p_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_stall) begin
        check(fr_valid && fr_data == p_data && fr_sof == p_sof && fr_eof == p_eof,
              "R9 hold under stall", fr_data, p_data);
      end
      if (fr_valid && fr_sof && !ts_seen_ok) begin
        ts_seen = cyc;
        ts_seen_ok = 1'b1;
      end
      if (fr_valid && fr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected word", fr_data, 32'h0);
        end else begin
          logic [31:0] e;
          int k;
          e = exp_q.pop_front();
          k = kind_q.pop_front();
          if (k == 1) e = {16'h0, ts_seen[31:16]};
          if (k == 2) e = {16'h0, ts_seen[15:0]};
          check(fr_data == e, req_of(widx), fr_data, e);
          check(fr_sof == (widx == 0) && fr_eof == (widx == FW - 1), "R8 markers",
                {30'h0, fr_sof, fr_eof}, {30'h0, widx == 0, widx == FW - 1});
        end
        widx++;
        if (widx == FW) begin
          widx = 0;
          ts_seen_ok = 1'b0;
        end
      end
      p_stall = fr_valid && !fr_ready;
      p_data = fr_data;
      p_sof = fr_sof;
      p_eof = fr_eof;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) seq[c] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!fr_valid, "R10 valid low in reset", {31'h0, fr_valid}, 32'h0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!fr_valid, "R10 valid low after reset", {31'h0, fr_valid}, 32'h0);

    // R6: one sample short of a payload in every channel
    write_burst(4'hF, 2*P - 1);
    repeat (30) @(negedge clk);
    check(!fr_valid, "R6 short buffers hold frame", {31'h0, fr_valid}, 32'h0);
    write_burst(4'hF, 1);
    drain();

    // R2/R9: several frames under backpressure with a new configuration
    bp_on = 1'b1;
    acq_cfg = 32'hC0FF_EE01;
    write_burst(4'hF, 6*P);
    drain();

    // R6: one channel starved
    write_burst(4'b0111, 2*P);
    repeat (30) @(negedge clk);
    check(!fr_valid, "R6 starved channel blocks frame", {31'h0, fr_valid}, 32'h0);
    write_burst(4'b1000, 2*P);
    drain();

    // R7: overrun channel 1 while no frame can start, then drain it
    write_burst(4'b0010, DEPTH + 3);
    repeat (10) @(negedge clk);
    check(!fr_valid, "R7 no frame while others empty", {31'h0, fr_valid}, 32'h0);
    acq_cfg = 32'h0BAD_F00D;
    write_burst(4'b1101, DEPTH);
    drain();

    // R7: status clears after being reported
    bp_on = 1'b0;
    write_burst(4'hF, 2*P);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule